// File: doc/BRIEF.md
# Multi-Format Serial Result Port

This block takes 16-bit results from a converter core and sends each one out on a single serial data line. It supports three line formats. In the first, each word goes out as two UART-style frames, and an external bit clock sets the pace. In the second, the word goes out raw, MSB first, shifted by an externally supplied serial clock. In the third, the port makes its own serial clock from the master clock. An active-low data-ready flag tells the host when a fresh word can be read. The host starts a transfer with the falling edge of an active-low select. The data and clock outputs each come with an output-enable, so the pads can be tri-stated when no transfer is running.

The core hands over results through a one-cycle load strobe. A new word goes into a holding register, and that word is copied into the shift register only when a transfer starts. The core can therefore deliver a result in the middle of a transfer without corrupting the word on the line. For four master cycles after each load, data-ready is forced inactive, and a select edge that arrives in that window is ignored. If the host raises select early, the port finishes the bit in progress and then releases the line. The word counts as still unread, so the next transfer sends it again from its first bit.

All inputs are sampled on the master clock. The external serial clock is therefore expected to run well below the master clock rate.

Top module: `serout_port`

## Requirements
- R1: While reset is held and in the cycle after it, rdyN is 1, sdataOe is 0 and sclkOe is 0.
- R2: A load strobe drives rdyN to 1 for exactly four master cycles, counted from the clock edge that samples the strobe. After those four cycles rdyN is 0, because an unsent word is held.
- R3: A falling edge of csN that is sampled while the four-cycle window of R2 is open starts no transfer: sdataOe stays 0 and the word stays pending with rdyN at 0. The next falling edge of csN outside the window starts the transfer.
- R4: With modeSel=00, a transfer has 22 bits: the high byte is sent first, then the low byte. Each byte goes out as a start bit of 0, its eight data bits LSB first, and two stop bits of 1. The line moves to the next bit on each falling edge of sclkIn, and sclkOe stays 0.
- R5: With modeSel=01, a transfer has 16 bits, sent MSB first, and sclkOe stays 0. The first bit is on the line once csN has fallen. Each falling edge of sclkIn moves to the next bit, and the 16th falling edge releases sdataOe.
- R6: With modeSel=10 or 11, sclkOe is 1 for the whole transfer. sclkOut is high for one master cycle out of every four, and that high cycle comes two cycles after a new bit is placed on the line. The 16 bits are sent MSB first, and sdataOe is 1 for exactly 64 cycles.
- R7: rdyN stays 0 while a transfer runs, unless R2 forces it high. It goes to 1 once the last bit of the word has been sent, provided no new load came during the transfer.
- R8: A load during a transfer leaves the bits still to come on the line unchanged. R2 applies to rdyN. After the transfer rdyN is 0, and the next falling edge of csN sends the new word.
- R9: If csN rises during a transfer, the bit in progress still completes, and then sdataOe drops. rdyN stays 0, and the next falling edge of csN sends the held word again from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | Line format: 00 framed bytes, 01 external clock, 1x self-clocked |
| loadStb | input | 1 | One-cycle strobe that delivers a new result |
| loadData | input | 16 | Result word, captured when loadStb is 1 |
| csN | input | 1 | Active-low select; its falling edge starts a transfer |
| sclkIn | input | 1 | External serial clock for formats 00 and 01 |
| sdataOut | output | 1 | Serial data value |
| sdataOe | output | 1 | Output enable for sdataOut (0 means high impedance) |
| sclkOut | output | 1 | Serial clock generated in the self-clocked format |
| sclkOe | output | 1 | Output enable for sclkOut |
| rdyN | output | 1 | Active-low data-ready flag |

## Verification
The hardest cases are those that depend on when an event lands relative to other activity. One is a select edge that falls one cycle after a load strobe, inside the blanking window. Another is a select that rises between two serial clock edges, in the middle of a bit. A third is a load that arrives halfway through a word. The stimulus drops csN right after the load strobe. It raises csN between sclkIn pulses after a chosen number of bits. It also issues a load between pulses in the middle of a word. After each of these, a scoreboard that holds the expected bits in order confirms exactly which bits reached the line, and rdyN and the enables are checked at the ports.

// File: rtl/serout_pkg.sv
package serout_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_EXT   = 2'b01,
    MODE_SELF  = 2'b10,
    MODE_SELF2 = 2'b11
  } modeT;

  // strobes passed from control to datapath
  typedef struct packed {
    logic takeLoad;
    logic startShift;
    logic advance;
    logic asyncFmt;
  } strobeT;
endpackage

// File: rtl/serout_dp.sv
module serout_dp
  import serout_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int STOP_BITS = 2,
  localparam int NBYTES   = WORD_W / BYTE_W,
  localparam int SLOT_W   = 1 + BYTE_W + STOP_BITS,
  localparam int FRAME_W  = NBYTES * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            stb,
  input  logic [WORD_W-1:0] loadData,
  output logic              bitOut
);
  logic [WORD_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] asyncFrame;
  logic [FRAME_W-1:0] syncFrame;

  // framed layout: bit 0 leaves first; high byte occupies the first slot
  for (genvar b = 0; b < NBYTES; b++) begin : g_slot
    assign asyncFrame[b*SLOT_W] = 1'b0;
    assign asyncFrame[b*SLOT_W+1 +: BYTE_W] = holdReg[WORD_W-1-b*BYTE_W -: BYTE_W];
    assign asyncFrame[b*SLOT_W+1+BYTE_W +: STOP_BITS] = '1;
  end

  // raw layout: MSB leaves first
  for (genvar i = 0; i < FRAME_W; i++) begin : g_raw
    if (i < WORD_W) begin : g_bit
      assign syncFrame[i] = holdReg[WORD_W-1-i];
    end else begin : g_pad
      assign syncFrame[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (stb.takeLoad) holdReg <= loadData;
      if (stb.startShift)
        shiftReg <= stb.asyncFmt ? asyncFrame : syncFrame;
      else if (stb.advance)
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign bitOut = shiftReg[0];

  assert_start_bit_low_R4: assert property (@(posedge clk) disable iff (rst)
    (stb.startShift && stb.asyncFmt) |=> !bitOut);

  assert_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
    (stb.startShift && !stb.asyncFmt) |=> (bitOut == $past(holdReg[WORD_W-1])));
endmodule

// File: rtl/serout_ctrl.sv
module serout_ctrl
  import serout_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int FRAME_W   = 22,
  parameter int BLANK_CYC = 4,
  parameter int SELF_DIV  = 4,
  localparam int CNT_W    = $clog2(FRAME_W + 1),
  localparam int BLANK_W  = $clog2(BLANK_CYC + 1),
  localparam int PH_W     = $clog2(SELF_DIV),
  localparam int HIGH_PH  = SELF_DIV / 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       loadStb,
  input  logic       csN,
  input  logic       sclkIn,
  output strobeT     stb,
  output logic       busy,
  output logic       clkOe,
  output logic       clkLvl,
  output logic       rdyN
);
  modeT             modeNow;
  logic             csPrev, sclkPrev;
  logic             valid, dirty, abortPend, isSelf;
  logic [CNT_W-1:0] bitsLeft;
  logic [PH_W-1:0]  phase;
  logic [BLANK_W-1:0] blankCnt;
  logic             csFall, sclkFall, blanking, startOk, bitEnd, lastBit;

  assign modeNow  = modeT'(modeSel);
  assign csFall   = csPrev & ~csN;
  assign sclkFall = sclkPrev & ~sclkIn;
  assign blanking = (blankCnt != '0);
  assign startOk  = !busy && csFall && dirty && !blanking && !loadStb;
  assign bitEnd   = busy && (isSelf ? (phase == PH_W'(SELF_DIV-1)) : sclkFall);
  assign lastBit  = bitEnd && ((bitsLeft == CNT_W'(1)) || abortPend || csN);

  always_comb begin
    stb.takeLoad   = loadStb;
    stb.startShift = startOk;
    stb.advance    = bitEnd && !lastBit;
    stb.asyncFmt   = (modeNow == MODE_ASYNC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csPrev    <= 1'b1;
      sclkPrev  <= 1'b0;
      busy      <= 1'b0;
      valid     <= 1'b0;
      dirty     <= 1'b0;
      abortPend <= 1'b0;
      isSelf    <= 1'b0;
      bitsLeft  <= '0;
      phase     <= '0;
      blankCnt  <= '0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclkIn;
      if (loadStb) blankCnt <= BLANK_W'(BLANK_CYC);
      else if (blanking) blankCnt <= blankCnt - 1'b1;

      if (startOk) begin
        busy      <= 1'b1;
        dirty     <= 1'b0;
        abortPend <= 1'b0;
        isSelf    <= modeSel[1];
        bitsLeft  <= (modeNow == MODE_ASYNC) ? CNT_W'(FRAME_W) : CNT_W'(WORD_W);
        phase     <= '0;
      end else if (busy) begin
        if (csN) abortPend <= 1'b1;
        if (isSelf) phase <= (phase == PH_W'(SELF_DIV-1)) ? '0 : phase + 1'b1;
        if (lastBit) begin
          busy <= 1'b0;
          if (bitsLeft != CNT_W'(1)) dirty <= 1'b1;   // cut short: resend later
          else valid <= dirty;                        // done: pending only if reloaded
        end else if (bitEnd) begin
          bitsLeft <= bitsLeft - 1'b1;
        end
      end

      if (loadStb) begin
        valid <= 1'b1;
        dirty <= 1'b1;
      end
    end
  end

  assign rdyN   = !(valid && !blanking);
  assign clkOe  = busy && isSelf;
  assign clkLvl = busy && isSelf && (phase == PH_W'(HIGH_PH));

  assert_blank_after_load_R2: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> rdyN);

  assert_no_start_in_blank_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(rdyN));

  assert_clk_single_high_R6: assert property (@(posedge clk) disable iff (rst)
    clkLvl |=> !clkLvl);

  assert_ready_low_in_tx_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !blanking) |-> !rdyN);

  assert_release_at_bit_end_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !bitEnd) |=> busy);
endmodule

// File: rtl/serout_port.sv
module serout_port
  import serout_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int STOP_BITS = 2,
  parameter int BLANK_CYC = 4,
  parameter int SELF_DIV  = 4,
  localparam int FRAME_W  = (WORD_W / BYTE_W) * (1 + BYTE_W + STOP_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        modeSel,
  input  logic              loadStb,
  input  logic [WORD_W-1:0] loadData,
  input  logic              csN,
  input  logic              sclkIn,
  output logic              sdataOut,
  output logic              sdataOe,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              rdyN
);
  strobeT stb;
  logic   busy, bitOut;

  serout_ctrl #(
    .WORD_W(WORD_W), .FRAME_W(FRAME_W), .BLANK_CYC(BLANK_CYC), .SELF_DIV(SELF_DIV)
  ) u_ctrl (
    .clk(clk), .rst(rst), .modeSel(modeSel), .loadStb(loadStb), .csN(csN),
    .sclkIn(sclkIn), .stb(stb), .busy(busy), .clkOe(sclkOe), .clkLvl(sclkOut),
    .rdyN(rdyN)
  );

  serout_dp #(
    .WORD_W(WORD_W), .BYTE_W(BYTE_W), .STOP_BITS(STOP_BITS)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .loadData(loadData), .bitOut(bitOut)
  );

  assign sdataOe  = busy;
  assign sdataOut = busy & bitOut;
endmodule

// File: tb/serout_port_bench.sv
module serout_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] modeSel = 2'b01;
  logic loadStb = 1'b0;
  logic [15:0] loadData = '0;
  logic csN = 1'b1;
  logic sclkIn = 1'b0;
  logic sdataOut, sdataOe, sclkOut, sclkOe, rdyN;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic expQ[$];
  string curTag = "R5";
  logic prevSclk = 1'b0;
  logic expBit;

  always #4 clk = ~clk;

  serout_port u_serout_port (
    .clk(clk), .rst(rst), .modeSel(modeSel), .loadStb(loadStb), .loadData(loadData),
    .csN(csN), .sclkIn(sclkIn), .sdataOut(sdataOut), .sdataOe(sdataOe),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .rdyN(rdyN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected bit at every sampling point of the line
  always @(negedge clk) begin
    if (!rst && sdataOe && ((sclkOe && sclkOut) || (!sclkOe && sclkIn && !prevSclk))) begin
      if (expQ.size() == 0) check(1'b0, curTag, int'(sdataOut), 2);
      else begin
        expBit = expQ.pop_front();
        check(sdataOut == expBit, curTag, int'(sdataOut), int'(expBit));
      end
    end
    prevSclk = sclkIn;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic loadWord(input logic [15:0] d);
    tick(1);
    loadStb = 1'b1;
    loadData = d;
    tick(1);
    loadStb = 1'b0;
  endtask

  task automatic pushRaw(input logic [15:0] d, input int n);
    for (int i = 15; i > 15 - n; i--) expQ.push_back(d[i]);
  endtask

  task automatic pushFramed(input logic [15:0] d);
    for (int b = 1; b >= 0; b--) begin
      expQ.push_back(1'b0);
      for (int i = 0; i < 8; i++) expQ.push_back(d[b*8+i]);
      expQ.push_back(1'b1);
      expQ.push_back(1'b1);
    end
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      sclkIn = 1'b1;
      tick(2);
      sclkIn = 1'b0;
      tick(2);
    end
  endtask

  task automatic startTx;
    csN = 1'b1;
    tick(1);
    csN = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int oeCnt;
    int hiCnt;
    // R1 reset state
    tick(3);
    check(rdyN == 1'b1, "R1 rdyN", int'(rdyN), 1);
    check(sdataOe == 1'b0, "R1 sdataOe", int'(sdataOe), 0);
    check(sclkOe == 1'b0, "R1 sclkOe", int'(sclkOe), 0);
    rst = 1'b0;
    tick(1);
    check(rdyN == 1'b1 && !sdataOe && !sclkOe, "R1 after", int'({rdyN, sdataOe, sclkOe}), 4);

    // R2 four-cycle blanking after load
    loadWord(16'hA5C3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(rdyN == (i < 4), "R2 blank", int'(rdyN), int'(i < 4));
    end

    // R5 external clock, MSB first; R7 ready during and after
    curTag = "R5 bit";
    modeSel = 2'b01;
    tick(1);
    pushRaw(16'hA5C3, 16);
    startTx();
    check(sclkOe == 1'b0, "R5 sclkOe", int'(sclkOe), 0);
    pulses(8);
    check(rdyN == 1'b0, "R7 mid", int'(rdyN), 0);
    pulses(8);
    check(sdataOe == 1'b0, "R5 release", int'(sdataOe), 0);
    check(expQ.size() == 0, "R5 count", expQ.size(), 0);
    check(rdyN == 1'b1, "R7 done", int'(rdyN), 1);
    csN = 1'b1;

    // R4 framed bytes
    curTag = "R4 bit";
    modeSel = 2'b00;
    loadWord(16'h3C96);
    tick(6);
    pushFramed(16'h3C96);
    startTx();
    check(sclkOe == 1'b0, "R4 sclkOe", int'(sclkOe), 0);
    pulses(22);
    check(sdataOe == 1'b0, "R4 release", int'(sdataOe), 0);
    check(expQ.size() == 0, "R4 count", expQ.size(), 0);
    csN = 1'b1;

    // R6 self-clocked
    curTag = "R6 bit";
    modeSel = 2'b10;
    loadWord(16'h9E21);
    tick(6);
    pushRaw(16'h9E21, 16);
    csN = 1'b0;
    oeCnt = 0;
    hiCnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sdataOe) oeCnt++;
      if (sclkOut && sclkOe) hiCnt++;
    end
    check(oeCnt == 64, "R6 oe cycles", oeCnt, 64);
    check(hiCnt == 16, "R6 clk highs", hiCnt, 16);
    check(expQ.size() == 0, "R6 count", expQ.size(), 0);
    check(sclkOe == 1'b0, "R6 clk release", int'(sclkOe), 0);
    tick(1);
    csN = 1'b1;

    // R3 select edge inside blanking is ignored
    curTag = "R3 bit";
    modeSel = 2'b01;
    loadWord(16'h1234);
    csN = 1'b0;
    tick(10);
    check(sdataOe == 1'b0, "R3 ignored", int'(sdataOe), 0);
    check(rdyN == 1'b0, "R3 pending", int'(rdyN), 0);
    pushRaw(16'h1234, 16);
    startTx();
    pulses(16);
    check(expQ.size() == 0, "R3 later start", expQ.size(), 0);
    csN = 1'b1;

    // R8 reload during transfer
    curTag = "R8 bit";
    loadWord(16'hBEEF);
    tick(6);
    pushRaw(16'hBEEF, 16);
    startTx();
    pulses(6);
    loadWord(16'h0F0F);
    check(rdyN == 1'b1, "R8 blank", int'(rdyN), 1);
    pulses(10);
    check(expQ.size() == 0, "R8 old word", expQ.size(), 0);
    check(sdataOe == 1'b0, "R8 release", int'(sdataOe), 0);
    check(rdyN == 1'b0, "R8 pending", int'(rdyN), 0);
    pushRaw(16'h0F0F, 16);
    startTx();
    pulses(16);
    check(expQ.size() == 0, "R8 new word", expQ.size(), 0);
    check(rdyN == 1'b1, "R8 done", int'(rdyN), 1);
    csN = 1'b1;

    // R9 early deselect
    curTag = "R9 bit";
    loadWord(16'hC0DE);
    tick(6);
    pushRaw(16'hC0DE, 6);
    startTx();
    pulses(5);
    csN = 1'b1;
    tick(2);
    check(sdataOe == 1'b1, "R9 finish bit", int'(sdataOe), 1);
    pulses(1);
    check(sdataOe == 1'b0, "R9 release", int'(sdataOe), 0);
    check(rdyN == 1'b0, "R9 pending", int'(rdyN), 0);
    check(expQ.size() == 0, "R9 partial", expQ.size(), 0);
    pushRaw(16'hC0DE, 16);
    startTx();
    pulses(16);
    check(expQ.size() == 0, "R9 resend", expQ.size(), 0);
    check(rdyN == 1'b1, "R9 done", int'(rdyN), 1);
    csN = 1'b1;
    tick(2);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule